// File: doc/BRIEF.md
# DMA Channel Activation Controller

This block decides when one DMA channel begins a transfer and who services the channel's internal interrupt source. It watches an active-low request pin through a two-flop synchroniser and one selected internal interrupt request. It holds the channel's enable and steering configuration in a small register that software writes and reads. Address generation, byte counting, bus arbitration and the data movement stay outside. The downstream engine is represented only by a completion strobe (`xfer_done`) and a final-transfer qualifier (`xfer_last`).

An activation is a one-cycle `act_start` pulse. `act_internal` marks whether the internal interrupt caused it. The transfer-enable and master-enable bits follow a guarded set rule: once either bit has been cleared, by hardware or by software, a write of 1 is ignored until a register read has returned that bit as 0. Software that clears a bit and immediately sets it again, without reading it back, therefore leaves the bit cleared. A write of 0 to transfer-enable while a transfer is in flight is a forced termination. The running transfer still finishes, but the source interrupt flag is not acknowledged.

Top module: `dma_act_ctrl`

## Requirements
- R1: After reset the register reads 0, `act_start`, `irq_clear` and `irq_to_cpu` are low (with `irq_src` low), and no activation occurs until both enable bits have been set through the guarded rule.
- R2: Level mode (configuration bit 3 = 0): while the channel is enabled and idle, a low synchronised pin starts a transfer, including a low level that was already present before the enable write. A pin change reaches the request logic after two clock edges.
- R3: Edge mode (configuration bit 3 = 1): the first acceptance after enabling takes a low level that is already present. After that, only a high-to-low transition of the synchronised pin produces a new activation. A level that stays low after a completed transfer produces none.
- R4: When the steering bit (bit 2) is 1 and the channel is enabled and idle, a high `irq_src` starts a transfer with `act_internal` high, even if the request was pending before the enable write. When both sources are present in the same cycle, the pin wins.
- R5: `irq_to_cpu` equals `irq_src` whenever transfer-enable (bit 0) or the steering bit is 0. It is low when both are 1.
- R6: `irq_clear` pulses high, in the same cycle as `xfer_done`, only for an internally activated transfer that ends normally with steering still set.
- R7: A write of 0 to transfer-enable while a transfer is busy clears the bit at once. The running transfer continues until `xfer_done`, and that completion gives no `irq_clear`.
- R8: `xfer_done` together with `xfer_last` clears transfer-enable. `xfer_done` without `xfer_last` leaves it set, and the channel may activate again.
- R9: A write of 1 to transfer-enable (bit 0) or master-enable (bit 1) takes effect only if a read has returned that bit as 0 since the bit was last cleared by reset, by hardware or by a write of 0. Otherwise the write is ignored.
- R10: At most one activation is outstanding. No `act_start` occurs from an `act_start` until the next `xfer_done`, and never while either enable bit is 0.
- R11: Register layout: bit 0 transfer-enable, bit 1 master-enable, bit 2 steering (1 = the DMA takes the internal interrupt), bit 3 sensing mode. Bits 2 and 3 take the written value directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (marks zero reads for the guarded set rule) |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Current register value |
| req_pin_n | input | 1 | Asynchronous active-low transfer request pin |
| irq_src | input | 1 | Selected internal interrupt request (level) |
| xfer_done | input | 1 | Current transfer has completed |
| xfer_last | input | 1 | Qualifies `xfer_done` as the final transfer |
| act_start | output | 1 | One-cycle activation pulse |
| act_internal | output | 1 | Activation came from the internal interrupt |
| irq_to_cpu | output | 1 | Internal interrupt routed to the processor |
| irq_clear | output | 1 | Acknowledge that clears the source interrupt flag |

## Verification
The assertions assume that the environment never raises `reg_wr` and `reg_rd` in the same cycle. They also assume that `xfer_done` is pulsed only while a transfer started by `act_start` is running, and that `xfer_last` is high only together with `xfer_done`. The bench drives all strobes from tasks that each own a whole cycle, so reads and writes never overlap. It issues every completion only after the scoreboard has consumed the matching activation. The assertion linking a falling transfer-enable bit to a write or a final completion depends on that same discipline.

// File: rtl/dma_act_pkg.sv
`timescale 1ns/1ps
package dma_act_pkg;
  localparam int unsigned CFG_W   = 4;
  localparam int unsigned B_XFER  = 0;
  localparam int unsigned B_MAST  = 1;
  localparam int unsigned B_STEER = 2;
  localparam int unsigned B_EDGE  = 3;
  // bits [GATED_N-1:0] follow the read-before-set rule
  localparam int unsigned GATED_N = 2;
endpackage

// File: rtl/dma_act_sync.sv
`timescale 1ns/1ps
module dma_act_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dma_act_cfg.sv
`timescale 1ns/1ps
module dma_act_cfg
  import dma_act_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic [CFG_W-1:0] wdata,
  input  logic             hw_clr_xfer,
  output logic [CFG_W-1:0] cfg
);
  logic [GATED_N-1:0] hw_clr;

  always_comb begin
    hw_clr         = '0;
    hw_clr[B_XFER] = hw_clr_xfer;
  end

  // guarded enable bits: a set needs a prior read that returned zero
  for (genvar i = 0; i < GATED_N; i++) begin : g_gated
    logic bit_q, bit_d, seen_q, seen_d;

    always_comb begin
      bit_d  = bit_q;
      seen_d = seen_q;
      if (rd && !bit_q) seen_d = 1'b1;
      if (wr) begin
        if (wdata[i]) begin
          if (seen_q) begin
            bit_d  = 1'b1;
            seen_d = 1'b0;
          end
        end else begin
          bit_d  = 1'b0;
          seen_d = 1'b0;
        end
      end
      if (hw_clr[i]) begin
        bit_d  = 1'b0;
        seen_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bit_q  <= 1'b0;
        seen_q <= 1'b0;
      end else begin
        bit_q  <= bit_d;
        seen_q <= seen_d;
      end
    end

    assign cfg[i] = bit_q;
  end

  // plain bits take the written value
  for (genvar j = GATED_N; j < CFG_W; j++) begin : g_plain
    logic val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  val_q <= 1'b0;
      else if (wr) val_q <= wdata[j];
    end
    assign cfg[j] = val_q;
  end
endmodule

// File: rtl/dma_act_trig.sv
`timescale 1ns/1ps
module dma_act_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic xfer_en,
  input  logic steer,
  input  logic edge_mode,
  input  logic req_s,
  input  logic irq_src,
  input  logic xfer_done,
  input  logic xfer_last,
  output logic act_start,
  output logic act_internal,
  output logic irq_clear,
  output logic irq_to_cpu,
  output logic end_clr
);
  logic prev_q, prev_d;
  logic first_q, first_d;
  logic edge_q, edge_d;
  logic run_q, run_d;
  logic runint_q, runint_d;
  logic forced_q, forced_d;
  logic fall, pin_hit, int_hit;

  always_comb begin
    fall    = prev_q & ~req_s;
    pin_hit = edge_mode ? (fall | edge_q | (first_q & ~req_s)) : ~req_s;
    int_hit = irq_src & steer;

    act_start    = en & ~run_q & (pin_hit | int_hit);
    act_internal = act_start & ~pin_hit;

    prev_d   = req_s;
    first_d  = ~en ? 1'b1 : (act_start ? 1'b0 : first_q);
    edge_d   = ~en ? 1'b0 : (act_start ? 1'b0 : (fall ? 1'b1 : edge_q));
    run_d    = act_start ? 1'b1 : (xfer_done ? 1'b0 : run_q);
    runint_d = act_start ? act_internal : runint_q;
    forced_d = ~run_q ? 1'b0 : (~xfer_en ? 1'b1 : forced_q);

    irq_clear  = xfer_done & run_q & runint_q & ~forced_q & xfer_en & steer;
    irq_to_cpu = irq_src & ~(xfer_en & steer);
    end_clr    = xfer_done & xfer_last & run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b1;
      first_q  <= 1'b1;
      edge_q   <= 1'b0;
      run_q    <= 1'b0;
      runint_q <= 1'b0;
      forced_q <= 1'b0;
    end else begin
      prev_q   <= prev_d;
      first_q  <= first_d;
      edge_q   <= edge_d;
      run_q    <= run_d;
      runint_q <= runint_d;
      forced_q <= forced_d;
    end
  end
endmodule

// File: rtl/dma_act_ctrl.sv
`timescale 1ns/1ps
module dma_act_ctrl
  import dma_act_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [CFG_W-1:0] reg_wdata,
  output logic [CFG_W-1:0] reg_rdata,
  input  logic             req_pin_n,
  input  logic             irq_src,
  input  logic             xfer_done,
  input  logic             xfer_last,
  output logic             act_start,
  output logic             act_internal,
  output logic             irq_to_cpu,
  output logic             irq_clear
);
  logic [CFG_W-1:0] cfg;
  logic             req_s;
  logic             end_clr;

  dma_act_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(req_pin_n),
    .d_sync (req_s)
  );

  dma_act_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .rd         (reg_rd),
    .wdata      (reg_wdata),
    .hw_clr_xfer(end_clr),
    .cfg        (cfg)
  );

  dma_act_trig u_trig (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (cfg[B_XFER] & cfg[B_MAST]),
    .xfer_en     (cfg[B_XFER]),
    .steer       (cfg[B_STEER]),
    .edge_mode   (cfg[B_EDGE]),
    .req_s       (req_s),
    .irq_src     (irq_src),
    .xfer_done   (xfer_done),
    .xfer_last   (xfer_last),
    .act_start   (act_start),
    .act_internal(act_internal),
    .irq_clear   (irq_clear),
    .irq_to_cpu  (irq_to_cpu),
    .end_clr     (end_clr)
  );

  assign reg_rdata = cfg;
endmodule

// File: rtl/dma_act_ctrl_chk.sv
`timescale 1ns/1ps
module dma_act_ctrl_chk
  import dma_act_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [CFG_W-1:0] reg_wdata,
  input logic [CFG_W-1:0] reg_rdata,
  input logic             irq_src,
  input logic             xfer_done,
  input logic             xfer_last,
  input logic             act_start,
  input logic             irq_to_cpu,
  input logic             irq_clear
);
  assert_single_activation_R10: assert property (@(posedge clk) disable iff (!rst_n)
    act_start |=> !act_start);

  assert_start_needs_enables_R10: assert property (@(posedge clk) disable iff (!rst_n)
    act_start |-> (reg_rdata[B_XFER] && reg_rdata[B_MAST]));

  assert_cpu_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[B_XFER] || !reg_rdata[B_STEER]) |-> (irq_to_cpu == irq_src));

  assert_ack_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clear |-> (xfer_done && reg_rdata[B_STEER]));

  assert_set_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[B_XFER]) |-> $past(reg_wr && reg_wdata[B_XFER]));

  assert_clear_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rdata[B_XFER]) |-> $past((reg_wr && !reg_wdata[B_XFER]) || (xfer_done && xfer_last)));
endmodule

bind dma_act_ctrl dma_act_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq_src   (irq_src),
  .xfer_done (xfer_done),
  .xfer_last (xfer_last),
  .act_start (act_start),
  .irq_to_cpu(irq_to_cpu),
  .irq_clear (irq_clear)
);

// File: tb/dma_act_ctrl_tb.sv
`timescale 1ns/1ps
module dma_act_ctrl_tb;
  localparam logic [3:0] X = 4'h1, M = 4'h2, S = 4'h4, E = 4'h8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr, reg_rd;
  logic [3:0] reg_wdata;
  logic [3:0] reg_rdata;
  logic       req_pin_n, irq_src, xfer_done, xfer_last;
  logic       act_start, act_internal, irq_to_cpu, irq_clear;

  int checks = 0;
  int failures = 0;
  bit exp_q[$];

  always #10 clk = ~clk;

  dma_act_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_pin_n(req_pin_n),
    .irq_src(irq_src), .xfer_done(xfer_done), .xfer_last(xfer_last),
    .act_start(act_start), .act_internal(act_internal),
    .irq_to_cpu(irq_to_cpu), .irq_clear(irq_clear)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] exp, input string req);
    @(negedge clk);
    reg_rd = 1'b1;
    #1 check(reg_rdata == exp, req, reg_rdata, exp);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic done(input bit last, input bit exp_ack, input string req);
    @(negedge clk);
    xfer_done = 1'b1; xfer_last = last;
    #1 check(irq_clear == exp_ack, req, irq_clear, exp_ack);
    @(negedge clk);
    xfer_done = 1'b0; xfer_last = 1'b0;
  endtask

  // scoreboard monitor: every act_start must match a queued expectation
  always @(negedge clk) begin
    #2;
    if (rst_n === 1'b1 && act_start === 1'b1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected act_start", 1, 0);
      end else begin
        bit e;
        e = exp_q.pop_front();
        check(act_internal == e, "R2/R3/R4 activation source", act_internal, e);
      end
    end
  end

  initial begin
    #(200000 * 20);
    check(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    req_pin_n = 1'b1; irq_src = 1'b0; xfer_done = 1'b0; xfer_last = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check(reg_rdata == 4'h0, "R1 reg after reset", reg_rdata, 0);
    check(act_start == 1'b0, "R1 act_start", act_start, 0);
    check(irq_to_cpu == 1'b0 && irq_clear == 1'b0, "R1 irq outputs", irq_to_cpu, 0);

    // R9: set without prior zero read is ignored
    wr(M);
    rd(4'h0, "R9 master set ignored without read");
    wr(M);
    rd(M, "R9 master set after zero read");

    // R2: level mode, pin already low before enabling
    req_pin_n = 1'b0;
    idle(4);
    exp_q.push_back(1'b0);
    wr(M | X);
    idle(2);
    rd(M | X, "R11 enable bits read back");
    exp_q.push_back(1'b0);             // R2/R8 level still low re-triggers
    done(1'b0, 1'b0, "R6 no ack for pin transfer");
    idle(2);
    done(1'b1, 1'b0, "R6 no ack for pin transfer");
    rd(M, "R8 final completion clears transfer-enable");
    idle(3);

    // R3: edge mode, low level present at enable is accepted once
    exp_q.push_back(1'b0);
    wr(M | X | E);
    idle(2);
    done(1'b0, 1'b0, "R3 done in edge mode");
    idle(4);
    check(exp_q.size() == 0, "R3 held low gives no new activation", exp_q.size(), 0);
    req_pin_n = 1'b1;
    idle(3);
    exp_q.push_back(1'b0);
    req_pin_n = 1'b0;
    idle(4);
    check(exp_q.size() == 0, "R3 falling edge activates", exp_q.size(), 0);
    done(1'b1, 1'b0, "R3 final done");
    rd(M | E, "R8 transfer-enable cleared");
    req_pin_n = 1'b1;
    idle(3);

    // R5/R4: internal request pending before enable
    irq_src = 1'b1;
    #1 check(irq_to_cpu == 1'b1, "R5 to cpu with steering off", irq_to_cpu, 1);
    wr(M | S);
    #1 check(irq_to_cpu == 1'b1, "R5 to cpu while transfer-enable 0", irq_to_cpu, 1);
    rd(M | S, "R11 steering bit");
    exp_q.push_back(1'b1);
    wr(M | S | X);
    #1 check(irq_to_cpu == 1'b0, "R5 steered to dma", irq_to_cpu, 0);
    idle(2);
    check(exp_q.size() == 0, "R4 internal activation", exp_q.size(), 0);
    done(1'b1, 1'b1, "R6 ack on normal internal completion");
    #1 check(irq_to_cpu == 1'b1, "R5 to cpu after end", irq_to_cpu, 1);
    rd(M | S, "R8 cleared after internal end");

    // R7: forced termination
    exp_q.push_back(1'b1);
    wr(M | S | X);
    idle(2);
    wr(M | S);
    #1 check(irq_to_cpu == 1'b1, "R7 to cpu after forced stop", irq_to_cpu, 1);
    idle(3);
    done(1'b1, 1'b0, "R7 no ack after forced termination");
    idle(3);

    // R9: write of 0 cleared the read permission
    wr(M | S | X);
    idle(3);
    rd(M | S, "R9 set ignored after write of 0 without read");
    irq_src = 1'b0;
    idle(3);
    check(exp_q.size() == 0, "R10 all activations seen", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule